// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block decodes every data access of a small processor core whose 4 KB data space is split into 32 banks of 128 bytes. A direct access joins a 5-bit bank number with a 7-bit offset taken from the instruction. An indirect access presents a full 12-bit pointer. The block then steers the access to one of four regions.

The four regions are the core registers and the special-function registers, both of which live outside this block, the general-purpose RAM that is private to each bank, and a 16-byte common RAM that every bank sees. The block holds both RAM arrays. For the two outside regions it raises registered select strobes and muxes their read data into a single read port.

A parameter sets how many banks physically hold general-purpose RAM. Every location that is not backed reads as zero and ignores writes.

Top module: `bank_mem_decode`

## Requirements
- R1: A direct access (indirect=0) uses the 12-bit address {bank_sel[4:0], offset[6:0]}. The upper five bits are the bank and the lower seven are the in-bank offset.
- R2: An access to offsets 0x00..0x0B in any bank raises core_sel in the following cycle. sel_off then carries offset bits [4:0], and rdata returns core_rdata.
- R3: An access to offsets 0x0C..0x1F in any bank raises sfr_sel in the following cycle. sel_off then carries offset bits [4:0], and rdata returns sfr_rdata.
- R4: Offsets 0x20..0x6F of banks 0..GPR_BANKS-1 are general-purpose RAM that is private to each bank. A write in one bank is not seen at the same offset of another bank.
- R5: Offsets 0x70..0x7F of every bank address one shared 16-byte common RAM. A byte written from any bank reads back from all banks.
- R6: An indirect access (indirect=1) takes bank and offset from ind_addr[11:7] and ind_addr[6:0], and bank_sel has no effect on it.
- R7: General-purpose offsets in banks GPR_BANKS and above are unimplemented. They read as 0, and writes to them change no stored byte.
- R8: Read data and strobes appear exactly one clock after the access. In the cycle after a write access, rdata is 0 and sel_we is 1.
- R9: During and right after reset, and in the cycle after a clock with acc_en=0, core_sel, sfr_sel and sel_we are 0 and rdata is 0.
- R10: core_sel and sfr_sel are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | An access is made this cycle |
| wr_en | input | 1 | The access is a write |
| indirect | input | 1 | Use ind_addr instead of bank_sel/offset |
| bank_sel | input | 5 | Bank number for direct accesses |
| offset | input | 7 | In-bank offset for direct accesses |
| ind_addr | input | 12 | Full pointer for indirect accesses |
| wdata | input | 8 | Write data |
| core_rdata | input | 8 | Read data from the core register file |
| sfr_rdata | input | 8 | Read data from the special-function registers |
| rdata | output | 8 | Read data, one cycle after the access |
| core_sel | output | 1 | Registered core-register region strobe |
| sfr_sel | output | 1 | Registered special-function region strobe |
| sel_we | output | 1 | Registered write flag that goes with the strobes |
| sel_off | output | 5 | Registered low offset bits for the strobed register |
| sel_wdata | output | 8 | Registered write data for the strobed register |

## Verification
Bytes are written at the same offset of two different banks and read back, which tells private per-bank storage apart from aliased storage. A common-RAM byte is written from one bank and read from another, which tells the shared window apart from per-bank storage. Reads at the first and last offset of each region, and reads in banks far apart, show that region boundaries are decoded on the offset alone. Indirect accesses are made with a bank_sel that disagrees with the pointer, and writes to unbacked banks are followed by reads of backed bytes, which shows the pointer path and the write gating.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
  localparam int BANK_W = 5;
  localparam int OFF_W  = 7;
  localparam int ADDR_W = BANK_W + OFF_W;

  // region boundaries inside a bank (first offset of the next region)
  localparam logic [OFF_W-1:0] CORE_END = 7'h0C;
  localparam logic [OFF_W-1:0] SFR_END  = 7'h20;
  localparam logic [OFF_W-1:0] GPR_END  = 7'h70;

  localparam int GPR_DEPTH = int'(GPR_END) - int'(SFR_END);
  localparam int COM_DEPTH = (1 << OFF_W) - int'(GPR_END);

  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_CORE   = 3'd1,
    RG_SFR    = 3'd2,
    RG_GPR    = 3'd3,
    RG_COMMON = 3'd4
  } region_t;
endpackage

// File: rtl/bmd_addr_decode.sv
module bmd_addr_decode
  import bmd_pkg::*;
#(
  parameter int GPR_BANKS = 4
) (
  input  logic              acc_en,
  input  logic              indirect,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [OFF_W-1:0]  offset,
  input  logic [ADDR_W-1:0] ind_addr,
  output logic [BANK_W-1:0] bank,
  output logic [OFF_W-1:0]  off,
  output region_t           region
);
  logic [ADDR_W-1:0] addr;

  always_comb begin
    addr = indirect ? ind_addr : {bank_sel, offset};
    bank = addr[ADDR_W-1:OFF_W];
    off  = addr[OFF_W-1:0];
    if (!acc_en)
      region = RG_NONE;
    else if (off < CORE_END)
      region = RG_CORE;
    else if (off < SFR_END)
      region = RG_SFR;
    else if (off < GPR_END)
      region = (int'(bank) < GPR_BANKS) ? RG_GPR : RG_NONE;
    else
      region = RG_COMMON;
  end
endmodule

// File: rtl/bmd_gpr_array.sv
module bmd_gpr_array
  import bmd_pkg::*;
#(
  parameter int GPR_BANKS = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int SEL_W = (GPR_BANKS > 1) ? $clog2(GPR_BANKS) : 1;
  localparam int IDX_W = $clog2(GPR_DEPTH);

  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  rel;
  logic [DATA_W-1:0] bank_rd [GPR_BANKS];
  logic [SEL_W-1:0]  sel;

  always_comb begin
    rel = off - SFR_END;
    idx = rel[IDX_W-1:0];
    sel = bank[SEL_W-1:0];
  end

  for (genvar b = 0; b < GPR_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [GPR_DEPTH];
    logic              bank_we;

    always_comb bank_we = en && we && (int'(bank) == b);

    always_ff @(posedge clk) begin
      if (bank_we) mem[idx] <= wdata;
    end

    always_comb bank_rd[b] = mem[idx];
  end

  always_ff @(posedge clk) begin
    if (en && !we) q <= bank_rd[sel];
  end
endmodule

// File: rtl/bmd_common_ram.sv
module bmd_common_ram
  import bmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int IDX_W = $clog2(COM_DEPTH);

  logic [DATA_W-1:0] mem [COM_DEPTH];
  logic [IDX_W-1:0]  idx;

  always_comb idx = off[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (en && we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (en && !we) q <= mem[idx];
  end
endmodule

// File: rtl/bank_mem_decode.sv
module bank_mem_decode
  import bmd_pkg::*;
#(
  parameter int GPR_BANKS = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              wr_en,
  input  logic              indirect,
  input  logic [4:0]        bank_sel,
  input  logic [6:0]        offset,
  input  logic [11:0]       ind_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] core_rdata,
  input  logic [DATA_W-1:0] sfr_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              core_sel,
  output logic              sfr_sel,
  output logic              sel_we,
  output logic [4:0]        sel_off,
  output logic [DATA_W-1:0] sel_wdata
);
  logic [BANK_W-1:0] dec_bank;
  logic [OFF_W-1:0]  dec_off;
  region_t           dec_region;

  region_t           r_region, n_region;
  logic              r_we, n_we;
  logic [4:0]        r_off, n_off;
  logic [DATA_W-1:0] r_wdata, n_wdata;
  logic              wdata_en;

  logic              gpr_en, com_en;
  logic [DATA_W-1:0] gpr_q, com_q;

  bmd_addr_decode #(.GPR_BANKS(GPR_BANKS)) i_decode (
    .acc_en   (acc_en),
    .indirect (indirect),
    .bank_sel (bank_sel),
    .offset   (offset),
    .ind_addr (ind_addr),
    .bank     (dec_bank),
    .off      (dec_off),
    .region   (dec_region)
  );

  always_comb begin
    gpr_en = (dec_region == RG_GPR);
    com_en = (dec_region == RG_COMMON);
  end

  bmd_gpr_array #(.GPR_BANKS(GPR_BANKS), .DATA_W(DATA_W)) i_gpr (
    .clk   (clk),
    .en    (gpr_en),
    .we    (wr_en),
    .bank  (dec_bank),
    .off   (dec_off),
    .wdata (wdata),
    .q     (gpr_q)
  );

  bmd_common_ram #(.DATA_W(DATA_W)) i_common (
    .clk   (clk),
    .en    (com_en),
    .we    (wr_en),
    .off   (dec_off),
    .wdata (wdata),
    .q     (com_q)
  );

  // next-state for the response stage
  always_comb begin
    n_region = dec_region;
    n_we     = acc_en && wr_en;
    n_off    = dec_off[4:0];
    n_wdata  = wdata;
    wdata_en = acc_en && wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_region <= RG_NONE;
      r_we     <= 1'b0;
      r_off    <= '0;
    end else begin
      r_region <= n_region;
      r_we     <= n_we;
      r_off    <= n_off;
    end
  end

  always_ff @(posedge clk) begin
    if (wdata_en) r_wdata <= n_wdata;
  end

  always_comb begin
    core_sel  = (r_region == RG_CORE);
    sfr_sel   = (r_region == RG_SFR);
    sel_we    = r_we;
    sel_off   = r_off;
    sel_wdata = r_wdata;
    if (r_we) begin
      rdata = '0;
    end else begin
      unique case (r_region)
        RG_CORE:   rdata = core_rdata;
        RG_SFR:    rdata = sfr_rdata;
        RG_GPR:    rdata = gpr_q;
        RG_COMMON: rdata = com_q;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/bank_mem_decode_chk.sv
module bank_mem_decode_chk #(
  parameter int GPR_BANKS = 4,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              wr_en,
  input logic              indirect,
  input logic [4:0]        bank_sel,
  input logic [6:0]        offset,
  input logic [11:0]       ind_addr,
  input logic [DATA_W-1:0] core_rdata,
  input logic [DATA_W-1:0] rdata,
  input logic              core_sel,
  input logic              sfr_sel,
  input logic              sel_we,
  input logic [4:0]        sel_off
);
  logic [6:0] c_off;
  logic [4:0] c_bank;
  logic       c_unimpl;

  always_comb begin
    c_off    = indirect ? ind_addr[6:0]  : offset;
    c_bank   = indirect ? ind_addr[11:7] : bank_sel;
    c_unimpl = (c_off >= 7'h20) && (c_off < 7'h70) && (int'(c_bank) >= GPR_BANKS);
  end

  assert_core_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !indirect && (offset < 7'h0C) |=> core_sel && (sel_off == $past(offset[4:0])));

  assert_sfr_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !indirect && (offset >= 7'h0C) && (offset < 7'h20) |=> sfr_sel);

  assert_indirect_core_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && indirect && (ind_addr[6:0] < 7'h0C) |=> core_sel);

  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !wr_en && c_unimpl |=> (rdata == '0) && !core_sel && !sfr_sel);

  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && wr_en |=> sel_we && (rdata == '0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> !core_sel && !sfr_sel && !sel_we && (rdata == '0));

  assert_core_mux_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_sel && !sel_we |-> rdata == core_rdata);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_sel && sfr_sel));
endmodule

bind bank_mem_decode bank_mem_decode_chk #(.GPR_BANKS(GPR_BANKS), .DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .wr_en      (wr_en),
  .indirect   (indirect),
  .bank_sel   (bank_sel),
  .offset     (offset),
  .ind_addr   (ind_addr),
  .core_rdata (core_rdata),
  .rdata      (rdata),
  .core_sel   (core_sel),
  .sfr_sel    (sfr_sel),
  .sel_we     (sel_we),
  .sel_off    (sel_off)
);

// File: tb/test_bank_mem_decode.sv
module test_bank_mem_decode;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CORE_D = 8'hC5;
  localparam logic [7:0] SFR_D  = 8'h5A;

  typedef struct packed {
    logic       ind;
    logic       we;
    logic [4:0] bank;
    logic [6:0] off;
    logic [11:0] ia;
    logic [7:0] wd;
    logic [7:0] er;   // expected rdata one cycle later
    logic       ec;   // expected core_sel
    logic       es;   // expected sfr_sel
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 5'd0,  7'h20, 12'h000, 8'h11, 8'h00, 1'b0, 1'b0}, // R8 write bank0
    '{1'b0, 1'b1, 5'd1,  7'h20, 12'h000, 8'h22, 8'h00, 1'b0, 1'b0}, // R4 write bank1 same offset
    '{1'b0, 1'b0, 5'd0,  7'h20, 12'h000, 8'h00, 8'h11, 1'b0, 1'b0}, // R4 private
    '{1'b0, 1'b0, 5'd1,  7'h20, 12'h000, 8'h00, 8'h22, 1'b0, 1'b0}, // R4 private
    '{1'b0, 1'b1, 5'd3,  7'h70, 12'h000, 8'h33, 8'h00, 1'b0, 1'b0}, // R5 write common
    '{1'b0, 1'b0, 5'd9,  7'h70, 12'h000, 8'h00, 8'h33, 1'b0, 1'b0}, // R5 read other bank
    '{1'b0, 1'b1, 5'd31, 7'h7F, 12'h000, 8'h77, 8'h00, 1'b0, 1'b0}, // R5 last common byte
    '{1'b0, 1'b0, 5'd0,  7'h7F, 12'h000, 8'h00, 8'h77, 1'b0, 1'b0}, // R5
    '{1'b0, 1'b0, 5'd5,  7'h05, 12'h000, 8'h00, CORE_D, 1'b1, 1'b0}, // R2
    '{1'b0, 1'b0, 5'd30, 7'h0B, 12'h000, 8'h00, CORE_D, 1'b1, 1'b0}, // R2 last core
    '{1'b0, 1'b0, 5'd2,  7'h0C, 12'h000, 8'h00, SFR_D, 1'b0, 1'b1}, // R3 first sfr
    '{1'b0, 1'b0, 5'd2,  7'h1F, 12'h000, 8'h00, SFR_D, 1'b0, 1'b1}, // R3 last sfr
    '{1'b0, 1'b1, 5'd8,  7'h20, 12'h000, 8'h44, 8'h00, 1'b0, 1'b0}, // R7 write unimplemented
    '{1'b0, 1'b0, 5'd8,  7'h20, 12'h000, 8'h00, 8'h00, 1'b0, 1'b0}, // R7 reads 0
    '{1'b0, 1'b0, 5'd0,  7'h20, 12'h000, 8'h00, 8'h11, 1'b0, 1'b0}, // R7 nothing changed
    '{1'b0, 1'b0, 5'd4,  7'h30, 12'h000, 8'h00, 8'h00, 1'b0, 1'b0}, // R7 first unbacked bank
    '{1'b1, 1'b0, 5'd0,  7'h00, 12'h0A0, 8'h00, 8'h22, 1'b0, 1'b0}, // R6 indirect bank1
    '{1'b1, 1'b1, 5'd2,  7'h00, 12'h1A1, 8'h55, 8'h00, 1'b0, 1'b0}, // R6 indirect write bank3
    '{1'b0, 1'b0, 5'd3,  7'h21, 12'h000, 8'h00, 8'h55, 1'b0, 1'b0}, // R1 direct readback
    '{1'b1, 1'b0, 5'd7,  7'h21, 12'h80C, 8'h00, SFR_D, 1'b0, 1'b1}, // R6 pointer region
    '{1'b0, 1'b1, 5'd2,  7'h6F, 12'h000, 8'h66, 8'h00, 1'b0, 1'b0}, // R4 last gpr byte
    '{1'b0, 1'b0, 5'd2,  7'h6F, 12'h000, 8'h00, 8'h66, 1'b0, 1'b0}  // R4
  };

  logic        clk, rst_n, acc_en, wr_en, indirect;
  logic [4:0]  bank_sel, sel_off;
  logic [6:0]  offset;
  logic [11:0] ind_addr;
  logic [7:0]  wdata, core_rdata, sfr_rdata, rdata, sel_wdata;
  logic        core_sel, sfr_sel, sel_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  bank_mem_decode i_bank_mem_decode (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en), .indirect(indirect),
    .bank_sel(bank_sel), .offset(offset), .ind_addr(ind_addr), .wdata(wdata),
    .core_rdata(core_rdata), .sfr_rdata(sfr_rdata), .rdata(rdata),
    .core_sel(core_sel), .sfr_sel(sfr_sel), .sel_we(sel_we),
    .sel_off(sel_off), .sel_wdata(sel_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    acc_en   = 1'b1;
    wr_en    = v.we;
    indirect = v.ind;
    bank_sel = v.bank;
    offset   = v.off;
    ind_addr = v.ia;
    wdata    = v.wd;
  endtask

  task automatic check_vec(input int i);
    vec_t v = VECS[i];
    logic [6:0] eo = v.ind ? v.ia[6:0] : v.off;
    chk($sformatf("R8 rdata vec%0d", i), rdata, v.er);
    chk($sformatf("R2 core_sel vec%0d", i), {7'd0, core_sel}, {7'd0, v.ec});
    chk($sformatf("R3 sfr_sel vec%0d", i), {7'd0, sfr_sel}, {7'd0, v.es});
    chk($sformatf("R8 sel_we vec%0d", i), {7'd0, sel_we}, {7'd0, v.we});
    if (v.ec || v.es)
      chk($sformatf("R2 sel_off vec%0d", i), {3'd0, sel_off}, {3'd0, eo[4:0]});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; wr_en = 1'b0; indirect = 1'b0;
    bank_sel = '0; offset = '0; ind_addr = '0; wdata = '0;
    core_rdata = CORE_D; sfr_rdata = SFR_D;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset core_sel", {7'd0, core_sel}, 8'd0);
    chk("R9 reset sfr_sel",  {7'd0, sfr_sel},  8'd0);
    chk("R9 reset rdata",    rdata, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset rdata", rdata, 8'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check_vec(i);
    end

    // R9 idle cycle after a core access
    drive(VECS[8]);
    @(negedge clk);
    acc_en = 1'b0;
    @(negedge clk);
    chk("R9 idle core_sel", {7'd0, core_sel}, 8'd0);
    chk("R9 idle rdata", rdata, 8'd0);

    // R2 core mux follows core_rdata while strobe high
    drive(VECS[9]);
    core_rdata = 8'h3C;
    @(negedge clk);
    chk("R2 mux core_rdata", rdata, 8'h3C);
    acc_en = 1'b0;

    // R9 reset mid-run, RAM contents kept
    drive(VECS[10]);
    @(negedge clk);
    acc_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9 async reset sfr_sel", {7'd0, sfr_sel}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(VECS[3]);
    @(negedge clk);
    chk("R4 bank1 byte after reset", rdata, 8'h22);
    acc_en = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule